// File: doc/BRIEF.md
# Exception Entry Sequencer

This block runs the processor's entry into an exception handler. A request carries an exception code together with a snapshot of the program counter, the status word, the Thumb state flag and the high-vector control bit. From a fixed table the block finds the target processor mode, the vector offset, the interrupt mask bits to raise and the return-address offset. It then performs a two-step update: first it asks the register banker to switch to the target mode, then it writes the new status word, the saved status word, the link value and the redirected program counter.

Requests for exceptions outside the table are refused with an error pulse and leave everything unchanged. Choosing between simultaneous exceptions is done upstream of this block, so one request arrives at a time. A request that arrives while a sequence is still in progress is ignored.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset `busy_o`, `bank_req_o`, `wr_o`, `done_o` and `err_o` are all low.
- R2: Codes (code_i) select mode / vector / mask: 0 undefined instruction → mode 5'b11011, vector 0x04, I; 1 software interrupt → 5'b10011, 0x08, I; 2 prefetch abort and 3 breakpoint → 5'b10111, 0x0C, A+I; 4 data abort → 5'b10111, 0x10, A+I; 5 IRQ → 5'b10010, 0x18, A+I; 6 FIQ → 5'b10001, 0x1C, A+I+F. The status word has mode in bits [4:0], T at bit 5, F at bit 6, I at bit 7 and A at bit 8.
- R3: The return offset for an undefined instruction is 2 when `thumb_i` is high and 4 when it is low. The offset is 0 for a software interrupt, 8 for a data abort, and 4 for all other codes.
- R4: When `hivec_i` is high, 0xFFFF0000 is added to the vector address.
- R5: `spsr_o` equals the `cpsr_i` value that was sampled with the accepted request.
- R6: `cpsr_o` equals the old status word with bits [4:0] replaced by the target mode, the mask bits for the exception ORed in, T cleared, and all other bits kept.
- R7: `lr_o` equals the sampled PC plus the return offset, modulo 2^32. `pc_o` equals the vector address.
- R8: A valid request is accepted at a rising edge while idle. In the next cycle `bank_req_o` is high and `bank_mode_o` carries the target mode. In the cycle after that, `wr_o` and `done_o` are high with the outputs valid. The block is idle again in the following cycle.
- R9: Code 7 is unsupported. It gives a one-cycle `err_o` pulse in the cycle after acceptance, with no `bank_req_o` and no `wr_o`.
- R10: A request seen while `busy_o` is high is ignored. It does not change the committed values and does not start a further sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Exception request |
| code_i | input | 3 | Exception code |
| pc_i | input | 32 | Current program counter |
| cpsr_i | input | 32 | Current status word |
| thumb_i | input | 1 | Thumb state flag |
| hivec_i | input | 1 | High-vector select |
| busy_o | output | 1 | Sequence in progress |
| bank_req_o | output | 1 | Mode-switch request to the register banker |
| bank_mode_o | output | 5 | Target mode for the banker |
| wr_o | output | 1 | Commit strobe for the state writes |
| pc_o | output | 32 | New program counter |
| cpsr_o | output | 32 | New status word |
| spsr_o | output | 32 | Saved status word |
| lr_o | output | 32 | Link value |
| done_o | output | 1 | Sequence complete |
| err_o | output | 1 | Unsupported exception code |

## Verification
The hardest case to reach from the ports is a second request that lands inside a running sequence. The bench raises a request with a different code, PC and status word during the bank cycle. It then checks that the commit still carries the first request's values and that no bank request follows. The main sweep covers every code against both Thumb states and both vector bases, using status words with T, mask and upper bits set and clear. A PC near 2^32 is included so the link addition wraps.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN   = 32;
  localparam int CODE_W = 3;
  localparam int MODE_W = 5;
  localparam int OFS_W  = 4;
  localparam int VEC_W  = 8;

  localparam int BIT_T = 5;
  localparam int BIT_F = 6;
  localparam int BIT_I = 7;
  localparam int BIT_A = 8;

  typedef enum logic [MODE_W-1:0] {
    M_USR = 5'b10000, M_FIQ = 5'b10001, M_IRQ = 5'b10010,
    M_SVC = 5'b10011, M_ABT = 5'b10111, M_UND = 5'b11011
  } mode_e;

  typedef enum logic [CODE_W-1:0] {
    X_UNDEF = 3'd0, X_SWI = 3'd1, X_PABT = 3'd2, X_BKPT = 3'd3,
    X_DABT  = 3'd4, X_IRQ = 3'd5, X_FIQ  = 3'd6, X_BAD  = 3'd7
  } exc_e;

  typedef struct packed {
    logic             valid;
    mode_e            mode;
    logic [VEC_W-1:0] vec;
    logic             mask_a;
    logic             mask_i;
    logic             mask_f;
    logic [OFS_W-1:0] ofs;
  } entry_t;

  typedef enum logic [1:0] {S_IDLE, S_BANK, S_COMMIT} st_e;
endpackage

// File: rtl/exc_table.sv
module exc_table
  import exc_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  logic              thumb_i,
  output entry_t            ent_o
);
  always_comb begin
    ent_o = '{valid: 1'b1, mode: M_UND, vec: 8'h04,
              mask_a: 1'b0, mask_i: 1'b1, mask_f: 1'b0, ofs: 4'd4};
    unique case (exc_e'(code_i))
      X_UNDEF: ent_o.ofs = thumb_i ? 4'd2 : 4'd4;
      X_SWI: begin
        ent_o.mode = M_SVC; ent_o.vec = 8'h08; ent_o.ofs = 4'd0;
      end
      X_PABT, X_BKPT: begin
        ent_o.mode = M_ABT; ent_o.vec = 8'h0C; ent_o.mask_a = 1'b1;
      end
      X_DABT: begin
        ent_o.mode = M_ABT; ent_o.vec = 8'h10; ent_o.mask_a = 1'b1;
        ent_o.ofs  = 4'd8;
      end
      X_IRQ: begin
        ent_o.mode = M_IRQ; ent_o.vec = 8'h18; ent_o.mask_a = 1'b1;
      end
      X_FIQ: begin
        ent_o.mode = M_FIQ; ent_o.vec = 8'h1C; ent_o.mask_a = 1'b1;
        ent_o.mask_f = 1'b1;
      end
      default: begin
        ent_o.valid = 1'b0; ent_o.mode = M_USR; ent_o.vec = '0;
        ent_o.mask_i = 1'b0; ent_o.ofs = '0;
      end
    endcase
  end
endmodule

// File: rtl/exc_compose.sv
module exc_compose
  import exc_pkg::*;
#(
  parameter logic [XLEN-1:0] HI_BASE = 32'hFFFF_0000
) (
  input  entry_t          ent_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] cpsr_i,
  input  logic            hivec_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] cpsr_o,
  output logic [XLEN-1:0] lr_o
);
  logic [XLEN-1:0] vec_w;

  assign vec_w = {{(XLEN-VEC_W){1'b0}}, ent_i.vec};
  assign pc_o  = hivec_i ? vec_w + HI_BASE : vec_w;
  assign lr_o  = pc_i + {{(XLEN-OFS_W){1'b0}}, ent_i.ofs};

  always_comb begin
    cpsr_o              = cpsr_i;
    cpsr_o[MODE_W-1:0]  = ent_i.mode;
    cpsr_o[BIT_A]       = cpsr_i[BIT_A] | ent_i.mask_a;
    cpsr_o[BIT_I]       = cpsr_i[BIT_I] | ent_i.mask_i;
    cpsr_o[BIT_F]       = cpsr_i[BIT_F] | ent_i.mask_f;
    cpsr_o[BIT_T]       = 1'b0;
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter logic [XLEN-1:0] HI_BASE = 32'hFFFF_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   cpsr_i,
  input  logic              thumb_i,
  input  logic              hivec_i,
  output logic              busy_o,
  output logic              bank_req_o,
  output logic [MODE_W-1:0] bank_mode_o,
  output logic              wr_o,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   cpsr_o,
  output logic [XLEN-1:0]   spsr_o,
  output logic [XLEN-1:0]   lr_o,
  output logic              done_o,
  output logic              err_o
);
  entry_t          ent;
  logic [XLEN-1:0] n_pc, n_cpsr, n_lr;
  st_e             st_q;
  logic            err_q, accept;
  logic [MODE_W-1:0] mode_q;
  logic [XLEN-1:0] pc_q, cpsr_q, spsr_q, lr_q;

  exc_table u_table (.code_i(code_i), .thumb_i(thumb_i), .ent_o(ent));

  exc_compose #(.HI_BASE(HI_BASE)) u_compose (
    .ent_i(ent), .pc_i(pc_i), .cpsr_i(cpsr_i), .hivec_i(hivec_i),
    .pc_o(n_pc), .cpsr_o(n_cpsr), .lr_o(n_lr)
  );

  assign accept = req_i && (st_q == S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      err_q  <= 1'b0;
      mode_q <= '0;
      pc_q   <= '0;
      cpsr_q <= '0;
      spsr_q <= '0;
      lr_q   <= '0;
    end else begin
      err_q <= accept && !ent.valid;
      unique case (st_q)
        S_IDLE: if (accept && ent.valid) begin
          st_q   <= S_BANK;
          mode_q <= ent.mode;
          pc_q   <= n_pc;
          cpsr_q <= n_cpsr;
          spsr_q <= cpsr_i;
          lr_q   <= n_lr;
        end
        S_BANK:   st_q <= S_COMMIT;
        default:  st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = st_q != S_IDLE;
  assign bank_req_o  = st_q == S_BANK;
  assign bank_mode_o = mode_q;
  assign wr_o        = st_q == S_COMMIT;
  assign done_o      = st_q == S_COMMIT;
  assign err_o       = err_q;
  assign pc_o        = pc_q;
  assign cpsr_o      = cpsr_q;
  assign spsr_o      = spsr_q;
  assign lr_o        = lr_q;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              bank_req_o,
  input logic [MODE_W-1:0] bank_mode_o,
  input logic              wr_o,
  input logic [XLEN-1:0]   cpsr_i,
  input logic [XLEN-1:0]   cpsr_o,
  input logic [XLEN-1:0]   spsr_o,
  input logic              err_o
);
  a_r8_bank_then_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_req_o |=> wr_o);
  a_r8_commit_then_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !busy_o);
  a_r9_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!bank_req_o && !wr_o));
  a_r6_mode_matches_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> cpsr_o[MODE_W-1:0] == $past(bank_mode_o));
  a_r6_thumb_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> !cpsr_o[BIT_T]);
  a_r5_spsr_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> spsr_o == $past(cpsr_i, 2));
  a_r10_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bank_req_o, wr_o, err_o}));
endmodule

bind exc_entry_seq exc_entry_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .bank_req_o(bank_req_o),
  .bank_mode_o(bank_mode_o), .wr_o(wr_o), .cpsr_i(cpsr_i), .cpsr_o(cpsr_o),
  .spsr_o(spsr_o), .err_o(err_o)
);

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [2:0]  code_i = '0;
  logic [31:0] pc_i = '0, cpsr_i = '0;
  logic        thumb_i = 1'b0, hivec_i = 1'b0;
  logic        busy_o, bank_req_o, wr_o, done_o, err_o;
  logic [4:0]  bank_mode_o;
  logic [31:0] pc_o, cpsr_o, spsr_o, lr_o;
  int          n_run = 0, n_fail = 0;
  bit          finished = 1'b0;

  always #5 clk_i = ~clk_i;

  exc_entry_seq u_dut (.*);

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  function automatic logic [4:0] e_mode(int c);
    case (c)
      0: return 5'b11011; 1: return 5'b10011; 2, 3, 4: return 5'b10111;
      5: return 5'b10010; default: return 5'b10001;
    endcase
  endfunction
  function automatic logic [31:0] e_vec(int c, bit hv);
    logic [31:0] v;
    case (c)
      0: v = 4; 1: v = 8; 2, 3: v = 12; 4: v = 16; 5: v = 24; default: v = 28;
    endcase
    return hv ? v + 32'hFFFF_0000 : v;
  endfunction
  function automatic logic [31:0] e_ofs(int c, bit th);
    case (c)
      0: return th ? 2 : 4; 1: return 0; 4: return 8; default: return 4;
    endcase
  endfunction
  function automatic logic [31:0] e_cpsr(int c, logic [31:0] old);
    logic [31:0] n = old;
    n[4:0] = e_mode(c);
    n[7] = 1'b1;
    if (c >= 2) n[8] = 1'b1;
    if (c == 6) n[6] = 1'b1;
    n[5] = 1'b0;
    return n;
  endfunction

  task automatic run_one(int c, bit th, bit hv, logic [31:0] pc, logic [31:0] ps);
    req_i = 1; code_i = 3'(c); thumb_i = th; hivec_i = hv; pc_i = pc; cpsr_i = ps;
    @(negedge clk_i);
    req_i = 0;
    if (c == 7) begin
      chk("R9 err", {31'b0, err_o}, 1);
      chk("R9 nobank", {31'b0, bank_req_o | busy_o}, 0);
      @(negedge clk_i);
      chk("R9 nowr", {29'b0, err_o, wr_o, bank_req_o}, 0);
      return;
    end
    chk("R8 bank", {31'b0, bank_req_o}, 1);
    chk("R2 mode", {27'b0, bank_mode_o}, {27'b0, e_mode(c)});
    @(negedge clk_i);
    chk("R8 wr/done", {30'b0, wr_o, done_o}, 3);
    chk("R2 R4 R7 pc", pc_o, e_vec(c, hv));
    chk("R3 R7 lr", lr_o, pc + e_ofs(c, th));
    chk("R5 spsr", spsr_o, ps);
    chk("R6 cpsr", cpsr_o, e_cpsr(c, ps));
    @(negedge clk_i);
    chk("R8 idle", {30'b0, busy_o, wr_o}, 0);
  endtask

  initial begin
    logic [31:0] pcs [4] = '{32'h0, 32'h0000_1000, 32'hFFFF_FFF8, 32'h8000_0002};
    logic [31:0] pss [4] = '{32'h0000_0030, 32'hF000_01D3, 32'h0000_0010, 32'hA5A5_5A3F};
    @(negedge clk_i);
    chk("R1 reset", {27'b0, busy_o, bank_req_o, wr_o, done_o, err_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int c = 0; c < 8; c++)
      for (int t = 0; t < 2; t++)
        for (int h = 0; h < 2; h++)
          for (int k = 0; k < 4; k++)
            run_one(c, t[0], h[0], pcs[k], pss[k]);
    // R10: request during bank cycle is dropped
    req_i = 1; code_i = 3'd4; thumb_i = 0; hivec_i = 0; pc_i = 32'h100; cpsr_i = 32'h10;
    @(negedge clk_i);
    code_i = 3'd6; pc_i = 32'h200; cpsr_i = 32'h1F;
    @(negedge clk_i);
    req_i = 0;
    chk("R10 pc", pc_o, 32'h10);
    chk("R10 lr", lr_o, 32'h108);
    chk("R10 spsr", spsr_o, 32'h10);
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R10 nosecond", {30'b0, bank_req_o, busy_o}, 0);
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk_i);
        n_run++; n_fail++;
        $display("FAIL watchdog act=hung exp=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule